// File: doc/BRIEF.md
# Wide-Word Byte Reassembler

This block sits behind the receive half of a serial transceiver, after word alignment and 8b/10b decoding. On every clock it takes one decoded byte, a flag that marks the byte as a control character, and a flag from the decoder that reports a code or disparity violation. Consecutive data bytes are gathered into a word of `VEC_W` bits. When the last byte of a word arrives, the block presents the word together with a strobe that is high for exactly one cycle. The consumer must capture the word on that cycle.

Any control character puts the block into its synchronisation state and throws away a partly gathered word. Gathering then starts again with the next data byte, so the transmitter re-frames the link by inserting a control character. The byte that was received first becomes the most significant byte of the word. When `VEC_W` is not a multiple of eight, the unused low bits of the final byte are dropped. Decoder errors are passed to the user as a one-cycle flag. They do not change the framing.

Top module: `lvd_byte_deser`

## Requirements
- R1: While rst_ni is low and after it is released, vec_vld_o and err_o are 0 and vec_o is all zeros until the first word completes.
- R2: A byte with ctrl_det_i = 0 is a data byte. After NBYTES = ceil(VEC_W/8) consecutive data bytes, vec_vld_o is high in the cycle after the clock edge that samples the last of them.
- R3: Byte order follows arrival order. The first data byte of a word occupies vec_o[VEC_W-1 -: 8] and each later byte sits in the next lower eight bits.
- R4: vec_vld_o lasts exactly one cycle for each word. An unbroken stream of data bytes yields one strobe every NBYTES cycles.
- R5: A byte with ctrl_det_i = 1 discards any partial word. Only the next NBYTES data bytes form the following word.
- R6: No sequence made only of control bytes ever raises vec_vld_o.
- R7: err_o is high for one cycle, the cycle after each edge that samples dec_err_i = 1. This holds for both data and control bytes.
- R8: When VEC_W is not a multiple of 8, vec_o carries the NBYTES*8 gathered bits with the lowest NBYTES*8-VEC_W bits removed. These are the low bits of the last byte.
- R9: vec_o keeps its value in every cycle in which vec_vld_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Decoded byte, one per cycle |
| ctrl_det_i | input | 1 | 1 marks byte_i as a control character |
| dec_err_i | input | 1 | Decoder code or disparity error for byte_i |
| vec_o | output | VEC_W | Reassembled word |
| vec_vld_o | output | 1 | One-cycle strobe marking a new word on vec_o |
| err_o | output | 1 | Registered error flag |

## Verification
The hardest case to reach is a control character that lands inside a word, after part of it has been gathered. Old bytes are still in the history register, so a wrong restart could place them in the next word or raise the strobe too early. The bench sends two data bytes, then a control byte, then three fresh bytes. It checks that the strobe stays low until the third fresh byte and that the word holds only the fresh bytes. The default width of 20 bits also exercises the padding drop on every word.

// File: rtl/lvd_pkg.sv
package lvd_pkg;

  typedef enum logic {
    FRM_SYNC = 1'b0,
    FRM_RUN  = 1'b1
  } frm_state_e;

  function automatic int unsigned bytes_for(input int unsigned width);
    return (width + 7) / 8;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lvd_frame_ctrl.sv
module lvd_frame_ctrl
  import lvd_pkg::*;
#(
  parameter int unsigned NBYTES = 3,
  parameter int unsigned CNT_W  = cnt_bits(NBYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_det_i,
  output logic             shift_o,
  output logic             done_o,
  output logic             vld_o,
  output logic [CNT_W-1:0] cnt_o,
  output frm_state_e       state_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  frm_state_e       state_q, state_d;
  logic             vld_q;

  assign shift_o = !ctrl_det_i;
  assign done_o  = shift_o && (cnt_q == LAST);

  always_comb begin
    cnt_d   = cnt_q;
    state_d = state_q;
    if (ctrl_det_i) begin
      cnt_d   = '0;
      state_d = FRM_SYNC;
    end else begin
      state_d = FRM_RUN;
      cnt_d   = done_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      state_q <= FRM_SYNC;
      vld_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      state_q <= state_d;
      vld_q   <= done_o;
    end
  end

  assign vld_o   = vld_q;
  assign cnt_o   = cnt_q;
  assign state_o = state_q;

endmodule

// File: rtl/lvd_shift_buf.sv
module lvd_shift_buf #(
  parameter int unsigned VEC_W  = 20,
  parameter int unsigned NBYTES = (VEC_W + 7) / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             load_i,
  input  logic [7:0]       byte_i,
  output logic [VEC_W-1:0] vec_o
);

  localparam int unsigned FULL_W = NBYTES * 8;
  localparam int unsigned PAD    = FULL_W - VEC_W;

  logic [FULL_W-1:0] hist_q;
  logic [FULL_W-1:0] full_w;
  logic [VEC_W-1:0]  trim_w;
  logic [VEC_W-1:0]  vec_q;

  // newest byte enters at the bottom, oldest ends at the top
  assign full_w = (hist_q << 8) | FULL_W'(byte_i);

  generate
    if (PAD == 0) begin : g_exact
      assign trim_w = full_w;
    end else begin : g_pad
      assign trim_w = VEC_W'(full_w >> PAD);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else if (shift_i) begin
      hist_q <= full_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
    end else if (load_i) begin
      vec_q <= trim_w;
    end
  end

  assign vec_o = vec_q;

endmodule

// File: rtl/lvd_err_flag.sv
module lvd_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  output logic err_o
);

  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_i;
  end

  assign err_o = err_q;

endmodule

// File: rtl/lvd_byte_deser.sv
module lvd_byte_deser
  import lvd_pkg::*;
#(
  parameter int unsigned VEC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             ctrl_det_i,
  input  logic             dec_err_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o,
  output logic             err_o
);

  localparam int unsigned NBYTES = bytes_for(VEC_W);
  localparam int unsigned CNT_W  = cnt_bits(NBYTES);

  logic             shift_w;
  logic             done_w;
  logic [CNT_W-1:0] frm_cnt;
  frm_state_e       frm_state;

  lvd_frame_ctrl #(
    .NBYTES (NBYTES),
    .CNT_W  (CNT_W)
  ) i_frame_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_det_i (ctrl_det_i),
    .shift_o    (shift_w),
    .done_o     (done_w),
    .vld_o      (vec_vld_o),
    .cnt_o      (frm_cnt),
    .state_o    (frm_state)
  );

  lvd_shift_buf #(
    .VEC_W  (VEC_W),
    .NBYTES (NBYTES)
  ) i_shift_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_w),
    .load_i  (done_w),
    .byte_i  (byte_i),
    .vec_o   (vec_o)
  );

  lvd_err_flag i_err_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .err_i  (dec_err_i),
    .err_o  (err_o)
  );

endmodule

// File: rtl/lvd_checker.sv
module lvd_checker
  import lvd_pkg::*;
#(
  parameter int unsigned VEC_W  = 20,
  parameter int unsigned NBYTES = 3,
  parameter int unsigned CNT_W  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_det_i,
  input logic             dec_err_i,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_vld_o,
  input logic             err_o,
  input logic [CNT_W-1:0] frm_cnt,
  input frm_state_e       frm_state
);

  p_ctrl_no_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_det_i |=> !vec_vld_o);

  p_ctrl_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_det_i |=> (frm_cnt == '0 && frm_state == FRM_SYNC));

  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NBYTES > 1) && vec_vld_o |=> !vec_vld_o);

  p_err_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_err_i |=> err_o);

  p_err_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_err_i |=> !err_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_vld_o |-> $stable(vec_o));

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_cnt < CNT_W'(NBYTES) || NBYTES == (1 << CNT_W));

  p_last_is_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_vld_o) |-> $past(!ctrl_det_i));

endmodule

bind lvd_byte_deser lvd_checker #(
  .VEC_W  (VEC_W),
  .NBYTES (NBYTES),
  .CNT_W  (CNT_W)
) i_lvd_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_det_i (ctrl_det_i),
  .dec_err_i  (dec_err_i),
  .vec_o      (vec_o),
  .vec_vld_o  (vec_vld_o),
  .err_o      (err_o),
  .frm_cnt    (frm_cnt),
  .frm_state  (frm_state)
);

// File: tb/test_lvd_byte_deser.sv
module test_lvd_byte_deser;

  localparam int unsigned VEC_W = 20;
  localparam int unsigned WATCHDOG_CYC = 5000;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [7:0]       byte_i = '0;
  logic             ctrl_det_i = 1'b1;
  logic             dec_err_i = 1'b0;
  logic [VEC_W-1:0] vec_o;
  logic             vec_vld_o;
  logic             err_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lvd_byte_deser #(.VEC_W(VEC_W)) i_lvd_byte_deser (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .byte_i     (byte_i),
    .ctrl_det_i (ctrl_det_i),
    .dec_err_i  (dec_err_i),
    .vec_o      (vec_o),
    .vec_vld_o  (vec_vld_o),
    .err_o      (err_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the following posedge
  task automatic put(input bit ctrl, input logic [7:0] b, input bit err);
    @(negedge clk);
    ctrl_det_i = ctrl;
    byte_i     = b;
    dec_err_i  = err;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    #1;
    check(vec_vld_o == 1'b0, "R1 vld in reset", 32'(vec_vld_o), 0);
    check(err_o == 1'b0, "R1 err in reset", 32'(err_o), 0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    put(1'b1, 8'hBC, 1'b0);
    check(vec_o == '0, "R1 vec after reset", 32'(vec_o), 0);
    check(vec_vld_o == 1'b0, "R1 vld after reset", 32'(vec_vld_o), 0);
  endtask

  task automatic t_basic;
    logic [VEC_W-1:0] held;
    put(1'b0, 8'hA1, 1'b0);
    check(!vec_vld_o, "R2 early byte 1", 32'(vec_vld_o), 0);
    put(1'b0, 8'hB2, 1'b0);
    check(!vec_vld_o, "R2 early byte 2", 32'(vec_vld_o), 0);
    put(1'b0, 8'hC3, 1'b0);
    check(vec_vld_o, "R2 strobe on last byte", 32'(vec_vld_o), 1);
    check(vec_o == 20'hA1B2C, "R3 order", 32'(vec_o), 32'h000A1B2C);
    held = vec_o;
    put(1'b1, 8'hBC, 1'b0);
    check(!vec_vld_o, "R4 strobe width", 32'(vec_vld_o), 0);
    check(vec_o == held, "R9 hold", 32'(vec_o), 32'(held));
  endtask

  task automatic t_stream;
    int pulses = 0;
    for (int i = 0; i < 6; i++) begin
      put(1'b0, 8'(8'h10 + i), 1'b0);
      if (vec_vld_o) pulses++;
      if (i == 5) begin
        check(vec_vld_o, "R4 second strobe at byte 6", 32'(vec_vld_o), 1);
        check(vec_o == 20'h13141, "R3 stream word", 32'(vec_o), 32'h00013141);
      end
    end
    check(pulses == 2, "R4 strobe count", 32'(pulses), 2);
    put(1'b1, 8'hBC, 1'b0);
  endtask

  task automatic t_midctrl;
    int early = 0;
    put(1'b0, 8'hDE, 1'b0);
    put(1'b0, 8'hAD, 1'b0);
    put(1'b1, 8'h3C, 1'b0);
    if (vec_vld_o) early++;
    put(1'b0, 8'h55, 1'b0);
    if (vec_vld_o) early++;
    put(1'b0, 8'h66, 1'b0);
    if (vec_vld_o) early++;
    check(early == 0, "R5 no strobe from partial", 32'(early), 0);
    put(1'b0, 8'h7A, 1'b0);
    check(vec_vld_o, "R5 strobe after restart", 32'(vec_vld_o), 1);
    check(vec_o == 20'h55667, "R5 fresh word only", 32'(vec_o), 32'h00055667);
    put(1'b1, 8'hBC, 1'b0);
  endtask

  task automatic t_ctrl_run;
    int seen = 0;
    logic [VEC_W-1:0] held;
    held = vec_o;
    for (int i = 0; i < 10; i++) begin
      put(1'b1, 8'(8'hF0 + i), 1'b0);
      if (vec_vld_o) seen++;
    end
    check(seen == 0, "R6 control run", 32'(seen), 0);
    check(vec_o == held, "R9 hold over control run", 32'(vec_o), 32'(held));
  endtask

  task automatic t_err;
    put(1'b0, 8'h01, 1'b1);
    check(err_o, "R7 err on data byte", 32'(err_o), 1);
    put(1'b0, 8'h02, 1'b0);
    check(!err_o, "R7 err clears", 32'(err_o), 0);
    put(1'b1, 8'hBC, 1'b1);
    check(err_o, "R7 err on control byte", 32'(err_o), 1);
    put(1'b1, 8'hBC, 1'b0);
    check(!err_o, "R7 err one cycle", 32'(err_o), 0);
  endtask

  task automatic t_pad;
    put(1'b0, 8'h12, 1'b0);
    put(1'b0, 8'h34, 1'b0);
    put(1'b0, 8'h5F, 1'b0);
    check(vec_vld_o && vec_o == 20'h12345, "R8 low pad bits dropped",
          32'(vec_o), 32'h00012345);
    put(1'b0, 8'hFF, 1'b0);
    put(1'b0, 8'hFF, 1'b0);
    put(1'b0, 8'h0F, 1'b0);
    check(vec_vld_o && vec_o == 20'hFFFF0, "R8 pad from last byte",
          32'(vec_o), 32'h000FFFF0);
    put(1'b1, 8'hBC, 1'b0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_stream();
    t_midctrl();
    t_ctrl_run();
    t_err();
    t_pad();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule